// File: doc/BRIEF.md
# Panel Self-Refresh Sequencer

This block decides when a display panel stops receiving live frames and refreshes itself, and when live transmission resumes. A 32-bit control register selects one of three entry policies. Hardware timer mode counts consecutive identical frames at each vblank. Software timer mode follows a request bit. Persistent mode enters like hardware timer mode but stays in self-refresh until it is disabled, and software may request one-shot single-frame updates.

On entry the sequencer sends one or two frames with the self-refresh packet setting. It then either keeps the link transmitter on with idle symbols, or powers the main link down and, after a programmed number of clock cycles, the pixel PLL. On exit it powers the PLL up first, then the link, and returns to normal transmission at the next vblank.

States: DISABLED (0), INACTIVE (1), ENTRY (2), ACTIVE (3), SFU (4, single-frame update), EXIT (5). Transitions:
- Any state goes to DISABLED when the enable bit is clear or the reset bit is set.
- DISABLED goes to INACTIVE.
- INACTIVE goes to ENTRY on a counter hit (hardware or persistent mode) or while the request bit is set (software mode).
- ENTRY goes to ACTIVE after one or two vblanks.
- ACTIVE goes to EXIT on a non-identical vblank (hardware mode) or on a cleared request (software mode). In persistent mode, ACTIVE goes to SFU on an update write.
- SFU goes to ACTIVE at the next vblank.
- EXIT goes to INACTIVE at a vblank once the link has power again.

Top module: `psr_seq`

## Requirements
- R1: After reset, `cfg_rdata` is 0, `psr_state` is DISABLED (0), `link_pwr_en` and `pll_pwr_en` are 1 and `idle_symbols` is 0.
- R2: Register bit 0 enables and bit 1 resets the sequencer. The state leaves DISABLED for INACTIVE on the second clock edge after a write that sets bit 0 with bit 1 clear. A write that sets bit 1 forces DISABLED one edge later from any state and clears the counters.
- R3: Bits 3:2 select the mode: 00 hardware timer, 01 software timer, 10 persistent, 11 behaves as 00. In hardware and persistent mode, INACTIVE counts identical vblanks (`vblank` with `frame_same`=1) and goes to ENTRY at the vblank that takes the count above the threshold in bits 23:16. A vblank with `frame_same`=0 resets the count to zero.
- R4: In software timer mode, bit 8 set moves INACTIVE to ENTRY and bit 8 clear moves ACTIVE to EXIT, each one edge after the write edge. Identical vblanks cause no entry.
- R5: ENTRY goes to ACTIVE at the first vblank, or at the second when bit 10 is set.
- R6: In ACTIVE with bit 9 set, `link_pwr_en` and `pll_pwr_en` stay 1 and `idle_symbols` is 1.
- R7: In ACTIVE with bit 9 clear, `link_pwr_en` drops on entry and `pll_pwr_en` drops D clock cycles later, where D is bits 15:11. The PLL is never off while the link is on.
- R8: In hardware mode a vblank with `frame_same`=0 moves ACTIVE to EXIT. In persistent mode it has no effect.
- R9: EXIT keeps `pll_pwr_en` 1 from its first cycle, turns `link_pwr_en` on one cycle later, and moves to INACTIVE at the first vblank after that.
- R10: In persistent mode, writing 1 to bit 7 while ACTIVE moves to SFU on the next edge without any vblank. SFU powers the link and PLL, returns to ACTIVE at the next vblank, and restarts the PLL delay.
- R11: The read-back of bit 7 changes only at a vblank, when it takes the value "SFU was in progress".
- R12: The read-back returns bits 23:8 and 3:0 as written, bit 7 as in R11, and 0 in bits 31:24 and 6:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core display clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read-back |
| vblank | input | 1 | One-cycle vertical blank pulse |
| frame_same | input | 1 | Frame ending at this vblank equals the previous one |
| link_pwr_en | output | 1 | Main link power enable |
| pll_pwr_en | output | 1 | Pixel PLL power enable |
| idle_symbols | output | 1 | Transmitter on, sending idle symbols only |
| psr_state | output | 3 | Current state code |

## Verification
A register write takes effect on its own clock edge, so a state change it causes appears after the following edge. A vblank-driven change appears after the edge that samples the pulse. The PLL drops exactly D edges after the edge that enters ACTIVE. The bench drives inputs at the falling edge and samples after the falling edge that follows each counted rising edge. For the PLL delay it checks one edge before the drop and at the drop, so an off-by-one either way is reported.

// File: rtl/psr_pkg.sv
package psr_pkg;
    parameter int THR_W = 8;
    parameter int DLY_W = 5;

    localparam int B_EN   = 0;
    localparam int B_RST  = 1;
    localparam int B_MODE = 2;
    localparam int B_SFU  = 7;
    localparam int B_SWA  = 8;
    localparam int B_KEEP = 9;
    localparam int B_DBL  = 10;
    localparam int B_DLY  = 11;
    localparam int B_THR  = 16;

    typedef enum logic [2:0] {
        ST_DISABLED = 3'd0,
        ST_INACTIVE = 3'd1,
        ST_ENTRY    = 3'd2,
        ST_ACTIVE   = 3'd3,
        ST_SFU      = 3'd4,
        ST_EXIT     = 3'd5
    } psr_state_e;

    typedef enum logic [1:0] {
        MODE_HW   = 2'b00,
        MODE_SW   = 2'b01,
        MODE_PERS = 2'b10,
        MODE_HW2  = 2'b11
    } psr_mode_e;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic [DLY_W-1:0] dly;
        logic             dbl;
        logic             keep_tx;
        logic             sw_act;
        logic [1:0]       mode;
        logic             rst;
        logic             en;
    } psr_ctrl_t;
endpackage

// File: rtl/psr_cfg_reg.sv
module psr_cfg_reg
    import psr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    input  logic        vblank,
    input  logic        sfu_busy,
    output psr_ctrl_t   ctrl,
    output logic        sfu_pulse,
    output logic [31:0] rdata
);
    logic sfu_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            sfu_pulse <= 1'b0;
        end else begin
            sfu_pulse <= we && wdata[B_SFU];
            if (we) begin
                ctrl.en      <= wdata[B_EN];
                ctrl.rst     <= wdata[B_RST];
                ctrl.mode    <= wdata[B_MODE +: 2];
                ctrl.sw_act  <= wdata[B_SWA];
                ctrl.keep_tx <= wdata[B_KEEP];
                ctrl.dbl     <= wdata[B_DBL];
                ctrl.dly     <= wdata[B_DLY +: DLY_W];
                ctrl.thr     <= wdata[B_THR +: THR_W];
            end
        end
    end

    // read-back of the update bit refreshes only at vblank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sfu_rd <= 1'b0;
        else if (vblank) sfu_rd <= sfu_busy;
    end

    always_comb begin
        rdata                    = '0;
        rdata[B_EN]              = ctrl.en;
        rdata[B_RST]             = ctrl.rst;
        rdata[B_MODE +: 2]       = ctrl.mode;
        rdata[B_SFU]             = sfu_rd;
        rdata[B_SWA]             = ctrl.sw_act;
        rdata[B_KEEP]            = ctrl.keep_tx;
        rdata[B_DBL]             = ctrl.dbl;
        rdata[B_DLY +: DLY_W]    = ctrl.dly;
        rdata[B_THR +: THR_W]    = ctrl.thr;
    end

    assert_sfu_rd_vblank_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank |=> $stable(sfu_rd));
endmodule

// File: rtl/psr_same_counter.sv
module psr_same_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         vblank,
    input  logic         same,
    input  logic [W-1:0] thr,
    output logic         hit
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] cnt;
    logic [W:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt} + {1'b0, ONE};
    assign hit     = vblank && same && !clr && (cnt_nxt > {1'b0, thr});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (vblank) begin
            if (!same)
                cnt <= '0;
            else if (cnt != MAX)
                cnt <= cnt + ONE;
        end
    end

    assert_clear_on_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && !same) |=> (cnt == '0));
endmodule

// File: rtl/psr_pll_delay.sv
module psr_pll_delay #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         run,
    output logic         zero
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt;

    assign zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (run && !zero)
            cnt <= cnt - ONE;
    end

    assert_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !clr && cnt != '0) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/psr_fsm.sv
module psr_fsm
    import psr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  psr_ctrl_t  ctrl,
    input  logic       vblank,
    input  logic       same,
    input  logic       hit,
    input  logic       sfu_pulse,
    input  logic       dly_zero,
    output psr_state_e state,
    output logic       cnt_clr,
    output logic       dly_clr,
    output logic       dly_load,
    output logic       dly_run,
    output logic       link_pwr_en,
    output logic       pll_pwr_en,
    output logic       idle_symbols,
    output logic       sfu_busy
);
    psr_state_e nxt;
    logic       entry_cnt;
    logic       exit_step;
    logic       is_sw;
    logic       is_pers;

    assign is_sw   = (ctrl.mode == MODE_SW);
    assign is_pers = (ctrl.mode == MODE_PERS);

    // next-state decision
    always_comb begin
        nxt = state;
        if (!ctrl.en || ctrl.rst) begin
            nxt = ST_DISABLED;
        end else begin
            unique case (state)
                ST_DISABLED: nxt = ST_INACTIVE;
                ST_INACTIVE: begin
                    if (is_sw) begin
                        if (ctrl.sw_act) nxt = ST_ENTRY;
                    end else if (hit) begin
                        nxt = ST_ENTRY;
                    end
                end
                ST_ENTRY: begin
                    if (vblank && (entry_cnt == ctrl.dbl)) nxt = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (is_sw) begin
                        if (!ctrl.sw_act) nxt = ST_EXIT;
                    end else if (is_pers) begin
                        if (sfu_pulse) nxt = ST_SFU;
                    end else if (vblank && !same) begin
                        nxt = ST_EXIT;
                    end
                end
                ST_SFU: begin
                    if (vblank) nxt = ST_ACTIVE;
                end
                ST_EXIT: begin
                    if (vblank && exit_step) nxt = ST_INACTIVE;
                end
                default: nxt = ST_DISABLED;
            endcase
        end
    end

    // state register and sub-step counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_DISABLED;
            entry_cnt <= 1'b0;
            exit_step <= 1'b0;
        end else begin
            state     <= nxt;
            entry_cnt <= (state == ST_ENTRY && nxt == ST_ENTRY) ? (entry_cnt | vblank) : 1'b0;
            exit_step <= (state == ST_EXIT && nxt == ST_EXIT);
        end
    end

    assign cnt_clr  = (state != ST_INACTIVE) || ctrl.rst || !ctrl.en;
    assign dly_clr  = (nxt == ST_DISABLED);
    assign dly_load = (nxt == ST_ACTIVE) && (state != ST_ACTIVE);
    assign dly_run  = (state == ST_ACTIVE);
    assign sfu_busy = (state == ST_SFU);

    // outputs
    always_comb begin
        link_pwr_en  = 1'b1;
        pll_pwr_en   = 1'b1;
        idle_symbols = 1'b0;
        unique case (state)
            ST_ACTIVE: begin
                link_pwr_en  = ctrl.keep_tx;
                pll_pwr_en   = ctrl.keep_tx || !dly_zero;
                idle_symbols = ctrl.keep_tx;
            end
            ST_EXIT: begin
                link_pwr_en  = ctrl.keep_tx || exit_step;
                pll_pwr_en   = 1'b1;
            end
            default: begin
                link_pwr_en  = 1'b1;
                pll_pwr_en   = 1'b1;
            end
        endcase
    end

    assert_pll_after_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_pwr_en |-> !link_pwr_en);

    assert_reset_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.rst |=> (state == ST_DISABLED));

    assert_sfu_from_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SFU && $past(state) != ST_SFU) |-> $past(sfu_pulse));

    assert_sfu_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SFU && vblank && ctrl.en && !ctrl.rst) |=> (state == ST_ACTIVE));

    assert_exit_pll_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXIT) |-> pll_pwr_en);
endmodule

// File: rtl/psr_seq.sv
module psr_seq
    import psr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        vblank,
    input  logic        frame_same,
    output logic        link_pwr_en,
    output logic        pll_pwr_en,
    output logic        idle_symbols,
    output logic [2:0]  psr_state
);
    psr_ctrl_t  ctrl;
    psr_state_e state;
    logic sfu_pulse, sfu_busy, hit;
    logic cnt_clr, dly_clr, dly_load, dly_run, dly_zero;

    psr_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .vblank(vblank), .sfu_busy(sfu_busy), .ctrl(ctrl),
        .sfu_pulse(sfu_pulse), .rdata(cfg_rdata)
    );

    psr_same_counter #(.W(THR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .vblank(vblank),
        .same(frame_same), .thr(ctrl.thr), .hit(hit)
    );

    psr_pll_delay #(.W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .clr(dly_clr), .load(dly_load),
        .val(ctrl.dly), .run(dly_run), .zero(dly_zero)
    );

    psr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .vblank(vblank),
        .same(frame_same), .hit(hit), .sfu_pulse(sfu_pulse),
        .dly_zero(dly_zero), .state(state), .cnt_clr(cnt_clr),
        .dly_clr(dly_clr), .dly_load(dly_load), .dly_run(dly_run),
        .link_pwr_en(link_pwr_en), .pll_pwr_en(pll_pwr_en),
        .idle_symbols(idle_symbols), .sfu_busy(sfu_busy)
    );

    assign psr_state = state;

    assert_idle_needs_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_symbols |-> (link_pwr_en && pll_pwr_en));
endmodule

// File: tb/psr_seq_tb.sv
module psr_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        vblank = 1'b0;
    logic        frame_same = 1'b0;
    logic        link_pwr_en, pll_pwr_en, idle_symbols;
    logic [2:0]  psr_state;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [2:0] S_DIS = 3'd0, S_INA = 3'd1, S_ENT = 3'd2,
                           S_ACT = 3'd3, S_SFU = 3'd4, S_EXI = 3'd5;

    always #2 clk = ~clk;

    psr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .vblank(vblank), .frame_same(frame_same),
        .link_pwr_en(link_pwr_en), .pll_pwr_en(pll_pwr_en),
        .idle_symbols(idle_symbols), .psr_state(psr_state)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_st(input string req, input logic [2:0] exp);
        chk(psr_state == exp, req, "state", psr_state, exp);
    endtask

    task automatic chk_pwr(input string req, input logic lk, input logic pl);
        chk(link_pwr_en == lk, req, "link_pwr_en", link_pwr_en, lk);
        chk(pll_pwr_en == pl, req, "pll_pwr_en", pll_pwr_en, pl);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        cfg_wdata = d;
        cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic vb(input logic same);
        vblank = 1'b1;
        frame_same = same;
        tick();
        vblank = 1'b0;
        frame_same = 1'b0;
    endtask

    function automatic logic [31:0] mk(input logic en, input logic rs, input logic [1:0] mode,
                                       input logic sw, input logic keep, input logic dbl,
                                       input logic [4:0] dly, input logic [7:0] thr);
        return {8'h00, thr, dly, dbl, keep, sw, 4'b0000, mode, rs, en};
    endfunction

    task automatic t_reset();
        chk(cfg_rdata == 32'h0, "R1", "rdata", cfg_rdata, 0);
        chk_st("R1", S_DIS);
        chk_pwr("R1", 1'b1, 1'b1);
        chk(idle_symbols == 1'b0, "R1", "idle", idle_symbols, 0);
    endtask

    task automatic t_regmap();
        wr(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'h00FF_FF0F, "R12", "rdata", cfg_rdata, 32'h00FF_FF0F);
        tick();
        chk_st("R2", S_DIS);
        wr(32'h0);
        tick();
    endtask

    task automatic t_hw_entry();
        wr(mk(1, 0, 2'b00, 0, 1, 0, 5'd0, 8'd2));
        chk_st("R2", S_DIS);
        tick();
        chk_st("R2", S_INA);
        vb(1); vb(1);
        chk_st("R3", S_INA);
        vb(0);
        vb(1); vb(1);
        chk_st("R3", S_INA);
        vb(1);
        chk_st("R3", S_ENT);
        vb(1);
        chk_st("R5", S_ACT);
        chk_pwr("R6", 1'b1, 1'b1);
        chk(idle_symbols == 1'b1, "R6", "idle", idle_symbols, 1);
        vb(1);
        chk_st("R8", S_ACT);
        vb(0);
        chk_st("R8", S_EXI);
        vb(1);
        chk_st("R9", S_EXI);
        vb(1);
        chk_st("R9", S_INA);
        wr(mk(1, 1, 2'b00, 0, 1, 0, 5'd0, 8'd2));
        tick();
        chk_st("R2", S_DIS);
        wr(32'h0);
        tick();
    endtask

    task automatic t_sw_power();
        wr(mk(1, 0, 2'b01, 1, 0, 1, 5'd3, 8'd0));
        tick();
        chk_st("R4", S_INA);
        tick();
        chk_st("R4", S_ENT);
        vb(1);
        chk_st("R5", S_ENT);
        vb(1);
        chk_st("R5", S_ACT);
        chk_pwr("R7", 1'b0, 1'b1);
        tick(); tick();
        chk_pwr("R7", 1'b0, 1'b1);
        tick();
        chk_pwr("R7", 1'b0, 1'b0);
        wr(mk(1, 0, 2'b01, 0, 0, 1, 5'd3, 8'd0));
        chk_st("R4", S_ACT);
        tick();
        chk_st("R4", S_EXI);
        chk_pwr("R9", 1'b0, 1'b1);
        tick();
        chk_pwr("R9", 1'b1, 1'b1);
        vb(1);
        chk_st("R9", S_INA);
        vb(1); vb(1); vb(1);
        chk_st("R4", S_INA);
        wr(32'h0);
        tick();
    endtask

    task automatic t_sfu();
        logic [31:0] base;
        base = mk(1, 0, 2'b10, 0, 0, 0, 5'd2, 8'd0);
        wr(base);
        tick();
        chk_st("R3", S_INA);
        vb(1);
        chk_st("R3", S_ENT);
        vb(1);
        chk_st("R5", S_ACT);
        tick(); tick();
        chk_pwr("R7", 1'b0, 1'b0);
        vb(0);
        chk_st("R8", S_ACT);
        wr(base | 32'h80);
        chk_st("R10", S_ACT);
        tick();
        chk_st("R10", S_SFU);
        chk_pwr("R10", 1'b1, 1'b1);
        chk(cfg_rdata[7] == 1'b0, "R11", "sfu readback", cfg_rdata[7], 0);
        vb(1);
        chk_st("R10", S_ACT);
        chk(cfg_rdata[7] == 1'b1, "R11", "sfu readback", cfg_rdata[7], 1);
        chk_pwr("R10", 1'b0, 1'b1);
        tick();
        chk_pwr("R10", 1'b0, 1'b1);
        tick();
        chk_pwr("R10", 1'b0, 1'b0);
        vb(1);
        chk(cfg_rdata[7] == 1'b0, "R11", "sfu readback", cfg_rdata[7], 0);
        wr(32'h0);
        tick();
        chk_st("R2", S_DIS);
    endtask

    initial begin
        #800000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_regmap();
        t_hw_entry();
        t_sw_power();
        t_sfu();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule